// File: doc/BRIEF.md
# 8-bit ALU with Status Flags

This block is the arithmetic and logic stage of a small 8-bit processor. Each cycle it takes two operands, the current status byte and an operation code. It computes an 8-bit result and a new status byte, and captures both in an output register. The values therefore appear one clock edge after the inputs that produced them. The surrounding datapath routes the result to its register file and returns the status byte on later operations.

Each operation rewrites only its own subset of flags and leaves the rest as they arrived. The interrupt-enable and transfer flags always pass through untouched. Subtract-with-carry and compare-with-carry can only clear Zero, never set it, so a chain of byte operations yields a Zero flag that covers the whole multi-byte value.

Status byte layout: bit 7 I, bit 6 T, bit 5 H (half carry), bit 4 S (sign), bit 3 V (overflow), bit 2 N (negative), bit 1 Z (zero), bit 0 C (carry).

Top module: `alu8_core`

## Requirements
- R1: While `rst_n` is low, `result_q` and `status_q` are 0. Outside reset, the outputs after a rising edge reflect the inputs sampled at that edge.
- R2: No operation changes status bits 7 and 6; they are copied from `status_in`.
- R3: ADD (code 0) yields a+b and ADC (code 1) yields a+b+C. For both: C is the carry out of bit 7, H is the carry out of bit 3, V is two's-complement overflow, N is result bit 7, and Z is set when the result is zero.
- R4: SUB (code 2) yields a-b, SBC (code 3) yields a-b-C, and NEG (code 5) yields 0-a. For all three: C is the borrow out of bit 7, H is the borrow from bit 4 into bit 3, V is signed overflow, and N is result bit 7. Z follows the result for SUB and NEG.
- R5: For SBC and CPC, Z becomes 1 only if the difference is zero and Z was already 1; otherwise Z is 0.
- R6: CPC (code 4) sets the flags exactly as SBC would, and returns operand a unchanged as the result.
- R7: AND (8), OR (9) and XOR (10) produce the bitwise result, clear V, set N and Z from the result, and keep C and H.
- R8: COM (11) yields 0xFF-a, sets C to 1, clears V, sets N and Z from the result, and keeps H.
- R9: INC (6) yields a+1 and DEC (7) yields a-1. Both set N and Z from the result and keep C and H. V is set only for INC of 0x7F and for DEC of 0x80.
- R10: LSL (12) shifts left and fills bit 0 with 0. LSR (13) shifts right and fills bit 7 with 0. ASR (16) shifts right and keeps bit 7. In each case C receives the bit shifted out, V = N xor C, N and Z follow the result, and H is kept.
- R11: ROL (14) moves the incoming C into bit 0 and bit 7 into C. ROR (15) moves the incoming C into bit 7 and bit 0 into C. V = N xor C, N and Z follow the result, and H is kept.
- R12: SWAP (17) exchanges bits 7..4 with bits 3..0. Codes 18 to 31 return operand a. In both cases the status byte is returned unchanged.
- R13: For every code from 0 to 16, S equals N xor V in the new status byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| op_code | input | 5 | Operation select (codes listed in the requirements) |
| opd_a | input | 8 | Destination operand |
| opd_b | input | 8 | Source operand or immediate |
| status_in | input | 8 | Incoming status byte |
| result_q | output | 8 | Registered result |
| status_q | output | 8 | Registered new status byte |

## Verification
The only state is the output register, so a wrong decode or a wrong flag equation appears at `result_q` or `status_q` one edge after the operands that trigger it. A flag that is preserved when it should be written, or written when it should be preserved, shows only if the incoming status byte holds the opposite value. For that reason every operation is driven with both polarities of the incoming flags. A broken Zero chain in compare-with-carry is visible only when a zero difference arrives with Z already cleared, and the directed tests build that case explicitly.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int OP_W = 5;
    localparam int SW   = 8;

    // status bit positions
    localparam int SB_C = 0;
    localparam int SB_Z = 1;
    localparam int SB_N = 2;
    localparam int SB_V = 3;
    localparam int SB_S = 4;
    localparam int SB_H = 5;
    localparam int SB_T = 6;
    localparam int SB_I = 7;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 5'd0,
        OP_ADC  = 5'd1,
        OP_SUB  = 5'd2,
        OP_SBC  = 5'd3,
        OP_CPC  = 5'd4,
        OP_NEG  = 5'd5,
        OP_INC  = 5'd6,
        OP_DEC  = 5'd7,
        OP_AND  = 5'd8,
        OP_OR   = 5'd9,
        OP_XOR  = 5'd10,
        OP_COM  = 5'd11,
        OP_LSL  = 5'd12,
        OP_LSR  = 5'd13,
        OP_ROL  = 5'd14,
        OP_ROR  = 5'd15,
        OP_ASR  = 5'd16,
        OP_SWAP = 5'd17
    } alu_op_e;

    // operations routed through the adder/subtractor
    function automatic logic uses_adder(alu_op_e op);
        return (op <= OP_DEC);
    endfunction

endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
    import alu8_pkg::*;
#(
    parameter int DW = 8
) (
    input  alu_op_e         op,
    input  logic [DW-1:0]   a,
    input  logic [DW-1:0]   b,
    input  logic            cin,
    output logic [DW-1:0]   res,
    output logic            c_out,
    output logic            h_out,
    output logic            v_out
);
    localparam int HB  = DW / 2;
    localparam int MSB = DW - 1;

    logic [DW-1:0] x;
    logic [DW-1:0] y;
    logic          ci;
    logic          sub;
    logic [DW:0]   full;
    logic [HB:0]   half;

    // operand steering
    always_comb begin
        x   = a;
        y   = b;
        ci  = 1'b0;
        sub = 1'b0;
        unique case (op)
            OP_ADC: ci = cin;
            OP_SUB: sub = 1'b1;
            OP_SBC, OP_CPC: begin
                sub = 1'b1;
                ci  = cin;
            end
            OP_NEG: begin
                x   = '0;
                y   = a;
                sub = 1'b1;
            end
            OP_INC: y = DW'(1);
            OP_DEC: begin
                y   = DW'(1);
                sub = 1'b1;
            end
            default: begin
            end
        endcase
    end

    // full-width and lower-half adders share the steering
    always_comb begin
        if (sub) begin
            full = {1'b0, x} - {1'b0, y} - {{DW{1'b0}}, ci};
            half = {1'b0, x[HB-1:0]} - {1'b0, y[HB-1:0]} - {{HB{1'b0}}, ci};
        end else begin
            full = {1'b0, x} + {1'b0, y} + {{DW{1'b0}}, ci};
            half = {1'b0, x[HB-1:0]} + {1'b0, y[HB-1:0]} + {{HB{1'b0}}, ci};
        end
    end

    always_comb begin
        res   = full[DW-1:0];
        c_out = full[DW];
        h_out = half[HB];
        if (sub) begin
            v_out = (x[MSB] != y[MSB]) && (full[MSB] != x[MSB]);
        end else begin
            v_out = (x[MSB] == y[MSB]) && (full[MSB] != x[MSB]);
        end
    end

endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
    import alu8_pkg::*;
#(
    parameter int DW = 8
) (
    input  alu_op_e         op,
    input  logic [DW-1:0]   a,
    input  logic [DW-1:0]   b,
    input  logic            cin,
    output logic [DW-1:0]   res,
    output logic            c_out
);
    localparam int HB  = DW / 2;
    localparam int MSB = DW - 1;

    always_comb begin
        res   = a;
        c_out = cin;
        unique case (op)
            OP_AND: res = a & b;
            OP_OR:  res = a | b;
            OP_XOR: res = a ^ b;
            OP_COM: begin
                res   = ~a;
                c_out = 1'b1;
            end
            OP_LSL: begin
                res   = {a[MSB-1:0], 1'b0};
                c_out = a[MSB];
            end
            OP_LSR: begin
                res   = {1'b0, a[MSB:1]};
                c_out = a[0];
            end
            OP_ROL: begin
                res   = {a[MSB-1:0], cin};
                c_out = a[MSB];
            end
            OP_ROR: begin
                res   = {cin, a[MSB:1]};
                c_out = a[0];
            end
            OP_ASR: begin
                res   = {a[MSB], a[MSB:1]};
                c_out = a[0];
            end
            OP_SWAP: res = {a[HB-1:0], a[MSB:HB]};
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
    import alu8_pkg::*;
#(
    parameter int DW = 8
) (
    input  alu_op_e         op,
    input  logic [SW-1:0]   old_s,
    input  logic [DW-1:0]   value,
    input  logic            ar_c,
    input  logic            ar_h,
    input  logic            ar_v,
    input  logic            bit_c,
    output logic [SW-1:0]   new_s
);
    logic neg;
    logic zro;
    logic upd_sign;

    assign neg = value[DW-1];
    assign zro = (value == '0);

    always_comb begin
        new_s    = old_s;
        upd_sign = 1'b1;
        unique case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_NEG: begin
                new_s[SB_C] = ar_c;
                new_s[SB_H] = ar_h;
                new_s[SB_V] = ar_v;
                new_s[SB_N] = neg;
                new_s[SB_Z] = zro;
            end
            OP_SBC, OP_CPC: begin
                new_s[SB_C] = ar_c;
                new_s[SB_H] = ar_h;
                new_s[SB_V] = ar_v;
                new_s[SB_N] = neg;
                new_s[SB_Z] = zro & old_s[SB_Z];
            end
            OP_INC, OP_DEC: begin
                new_s[SB_V] = ar_v;
                new_s[SB_N] = neg;
                new_s[SB_Z] = zro;
            end
            OP_AND, OP_OR, OP_XOR: begin
                new_s[SB_V] = 1'b0;
                new_s[SB_N] = neg;
                new_s[SB_Z] = zro;
            end
            OP_COM: begin
                new_s[SB_C] = bit_c;
                new_s[SB_V] = 1'b0;
                new_s[SB_N] = neg;
                new_s[SB_Z] = zro;
            end
            OP_LSL, OP_LSR, OP_ROL, OP_ROR, OP_ASR: begin
                new_s[SB_C] = bit_c;
                new_s[SB_V] = neg ^ bit_c;
                new_s[SB_N] = neg;
                new_s[SB_Z] = zro;
            end
            default: upd_sign = 1'b0;
        endcase
        if (upd_sign) begin
            new_s[SB_S] = new_s[SB_N] ^ new_s[SB_V];
        end
    end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [4:0]      op_code,
    input  logic [DW-1:0]   opd_a,
    input  logic [DW-1:0]   opd_b,
    input  logic [7:0]      status_in,
    output logic [DW-1:0]   result_q,
    output logic [7:0]      status_q
);
    alu_op_e       op;
    logic [DW-1:0] ar_res;
    logic          ar_c;
    logic          ar_h;
    logic          ar_v;
    logic [DW-1:0] bit_res;
    logic          bit_c;
    logic [DW-1:0] value;
    logic [DW-1:0] res_d;
    logic [7:0]    stat_d;

    assign op = alu_op_e'(op_code);

    alu8_arith #(.DW(DW)) u_arith (
        .op    (op),
        .a     (opd_a),
        .b     (opd_b),
        .cin   (status_in[SB_C]),
        .res   (ar_res),
        .c_out (ar_c),
        .h_out (ar_h),
        .v_out (ar_v)
    );

    alu8_bitops #(.DW(DW)) u_bitops (
        .op    (op),
        .a     (opd_a),
        .b     (opd_b),
        .cin   (status_in[SB_C]),
        .res   (bit_res),
        .c_out (bit_c)
    );

    // computed value feeds the flags; compare returns the operand
    always_comb begin
        value = uses_adder(op) ? ar_res : bit_res;
        res_d = (op == OP_CPC) ? opd_a : value;
    end

    alu8_flags #(.DW(DW)) u_flags (
        .op    (op),
        .old_s (status_in),
        .value (value),
        .ar_c  (ar_c),
        .ar_h  (ar_h),
        .ar_v  (ar_v),
        .bit_c (bit_c),
        .new_s (stat_d)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
            status_q <= '0;
        end else begin
            result_q <= res_d;
            status_q <= stat_d;
        end
    end

endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk
    import alu8_pkg::*;
#(
    parameter int DW = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic [4:0]      op_code,
    input logic [DW-1:0]   opd_a,
    input logic [7:0]      status_in,
    input logic [DW-1:0]   result_q,
    input logic [7:0]      status_q
);
    localparam int HB = DW / 2;

    logic [4:0]    p_op;
    logic [DW-1:0] p_a;
    logic [7:0]    p_s;
    logic          p_ok;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_ok <= 1'b0;
            p_op <= '0;
            p_a  <= '0;
            p_s  <= '0;
        end else begin
            p_ok <= 1'b1;
            p_op <= op_code;
            p_a  <= opd_a;
            p_s  <= status_in;
        end
    end

    // R2
    it_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        p_ok |-> status_q[7:6] == p_s[7:6]);

    // R12
    swap_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (p_ok && p_op == OP_SWAP) |->
            (status_q == p_s) && (result_q == {p_a[HB-1:0], p_a[DW-1:HB]}));

    // R13
    sign_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (p_ok && p_op <= OP_ASR) |-> status_q[SB_S] == (status_q[SB_N] ^ status_q[SB_V]));

    // R5
    sticky_z_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (p_ok && (p_op == OP_SBC || p_op == OP_CPC) && !p_s[SB_Z]) |-> !status_q[SB_Z]);

    // R6
    cpc_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (p_ok && p_op == OP_CPC) |-> result_q == p_a);

    // R7
    logic_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (p_ok && (p_op == OP_AND || p_op == OP_OR || p_op == OP_XOR)) |->
            (status_q[SB_C] == p_s[SB_C]) && (status_q[SB_H] == p_s[SB_H]) && !status_q[SB_V]);

    // R8
    com_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (p_ok && p_op == OP_COM) |->
            status_q[SB_C] && !status_q[SB_V] && (result_q == ~p_a));

    // R3
    zero_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (p_ok && p_op <= OP_ASR && p_op != OP_SBC && p_op != OP_CPC) |->
            status_q[SB_Z] == (result_q == '0));

endmodule

bind alu8_core alu8_core_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_code   (op_code),
    .opd_a     (opd_a),
    .status_in (status_in),
    .result_q  (result_q),
    .status_q  (status_q)
);

// File: tb/alu8_core_tb.sv
module alu8_core_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] op_code = '0;
    logic [7:0] opd_a = '0;
    logic [7:0] opd_b = '0;
    logic [7:0] status_in = '0;
    logic [7:0] result_q;
    logic [7:0] status_q;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    alu8_core u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_code   (op_code),
        .opd_a     (opd_a),
        .opd_b     (opd_b),
        .status_in (status_in),
        .result_q  (result_q),
        .status_q  (status_q)
    );

    function automatic int sx(input int v);
        return (v > 127) ? v - 256 : v;
    endfunction

    // reference model from the requirements, integer arithmetic
    function automatic logic [15:0] model(input int op, input int a, input int b,
                                          input logic [7:0] s);
        int r, d, ci, x, y, sv;
        logic [7:0] ns;
        bit nv;
        ns = s; r = a; nv = 1'b1;
        case (op)
            0, 1: begin
                ci = (op == 1) ? int'(s[0]) : 0;
                d = a + b + ci; r = d & 255;
                ns[0] = (d > 255);
                ns[5] = ((a & 15) + (b & 15) + ci) > 15;
                sv = sx(a) + sx(b) + ci;
                ns[3] = (sv > 127) || (sv < -128);
                ns[1] = (r == 0);
            end
            2, 3, 4, 5: begin
                ci = (op == 3 || op == 4) ? int'(s[0]) : 0;
                x = (op == 5) ? 0 : a;
                y = (op == 5) ? a : b;
                d = x - y - ci; r = d & 255;
                ns[0] = (d < 0);
                ns[5] = ((x & 15) - (y & 15) - ci) < 0;
                sv = sx(x) - sx(y) - ci;
                ns[3] = (sv > 127) || (sv < -128);
                ns[1] = (op == 3 || op == 4) ? ((r == 0) && s[1]) : (r == 0);
            end
            6:  begin r = (a + 1) & 255; ns[3] = (a == 127); ns[1] = (r == 0); end
            7:  begin r = (a + 255) & 255; ns[3] = (a == 128); ns[1] = (r == 0); end
            8:  begin r = a & b; ns[3] = 1'b0; ns[1] = (r == 0); end
            9:  begin r = a | b; ns[3] = 1'b0; ns[1] = (r == 0); end
            10: begin r = a ^ b; ns[3] = 1'b0; ns[1] = (r == 0); end
            11: begin r = 255 - a; ns[0] = 1'b1; ns[3] = 1'b0; ns[1] = (r == 0); end
            12, 13, 14, 15, 16: begin
                case (op)
                    12: begin r = (a * 2) & 255; ns[0] = (a >= 128); end
                    13: begin r = a / 2; ns[0] = (a % 2) == 1; end
                    14: begin r = ((a * 2) & 255) + int'(s[0]); ns[0] = (a >= 128); end
                    15: begin r = a / 2 + (s[0] ? 128 : 0); ns[0] = (a % 2) == 1; end
                    default: begin r = a / 2 + (a & 128); ns[0] = (a % 2) == 1; end
                endcase
                ns[1] = (r == 0);
                ns[3] = (r >= 128) ^ ns[0];
            end
            17: begin r = ((a % 16) * 16) + (a / 16); nv = 1'b0; end
            default: begin r = a; nv = 1'b0; end
        endcase
        if (nv) begin
            ns[2] = (r >= 128);
            ns[4] = ns[2] ^ ns[3];
        end
        if (op == 4) r = a;
        return {r[7:0], ns};
    endfunction

    task automatic run(input int op, input int a, input int b, input logic [7:0] s,
                       input string tag);
        logic [15:0] exp;
        exp = model(op, a, b, s);
        @(negedge clk);
        op_code = op[4:0]; opd_a = a[7:0]; opd_b = b[7:0]; status_in = s;
        @(negedge clk);
        checks++;
        if (result_q !== exp[15:8] || status_q !== exp[7:0]) begin
            fails++;
            $display("FAIL %s op=%0d a=%h b=%h s=%h: got res=%h st=%h expected res=%h st=%h",
                     tag, op, a, b, s, result_q, status_q, exp[15:8], exp[7:0]);
        end
    endtask

    task automatic t_reset();
        op_code = 5'd0; opd_a = 8'hFF; opd_b = 8'h01; status_in = 8'hFF;
        repeat (3) @(negedge clk);
        checks++;
        if (result_q !== 8'h00 || status_q !== 8'h00) begin
            fails++;
            $display("FAIL R1 reset: got res=%h st=%h expected res=00 st=00", result_q, status_q);
        end
        rst_n = 1'b1;
        run(0, 8'h12, 8'h34, 8'h00, "R1 latency");
    endtask

    task automatic t_add();
        run(0, 8'h0F, 8'h01, 8'h00, "R3 half carry");
        run(0, 8'h7F, 8'h01, 8'h00, "R3 overflow");
        run(0, 8'hFF, 8'h01, 8'h00, "R3 carry zero");
        run(1, 8'h10, 8'h20, 8'h01, "R3 adc carry in");
        run(1, 8'h80, 8'h80, 8'hC1, "R3 R2 adc wrap");
    endtask

    task automatic t_sub();
        run(2, 8'h10, 8'h01, 8'h00, "R4 half borrow");
        run(2, 8'h80, 8'h01, 8'h00, "R4 overflow");
        run(2, 8'h00, 8'h01, 8'h00, "R4 borrow");
        run(3, 8'h05, 8'h05, 8'h01, "R4 sbc borrow in");
        run(5, 8'h80, 8'h00, 8'h00, "R4 neg 80");
        run(5, 8'h00, 8'h00, 8'h3F, "R4 neg 00");
        run(5, 8'h01, 8'h00, 8'h00, "R4 neg 01");
    endtask

    task automatic t_sticky();
        run(3, 8'h05, 8'h05, 8'h02, "R5 sbc zero kept");
        run(3, 8'h05, 8'h05, 8'h00, "R5 sbc zero not set");
        run(3, 8'h06, 8'h05, 8'h02, "R5 sbc nonzero clears");
        run(4, 8'h22, 8'h22, 8'h00, "R5 cpc zero not set");
        run(4, 8'h22, 8'h21, 8'h03, "R6 cpc result a");
        run(4, 8'h00, 8'h01, 8'h02, "R6 cpc borrow");
    endtask

    task automatic t_logic();
        run(8, 8'hF0, 8'h0F, 8'h29, "R7 and zero keep C H");
        run(9, 8'h80, 8'h01, 8'h08, "R7 or clears V");
        run(10, 8'hAA, 8'h55, 8'h21, "R7 xor");
        run(11, 8'h00, 8'h00, 8'h08, "R8 com");
        run(11, 8'hFF, 8'h00, 8'h20, "R8 com zero");
    endtask

    task automatic t_incdec();
        run(6, 8'h7F, 8'h00, 8'h00, "R9 inc 7F");
        run(6, 8'hFF, 8'h00, 8'h21, "R9 inc FF keep C H");
        run(7, 8'h80, 8'h00, 8'h00, "R9 dec 80");
        run(7, 8'h00, 8'h00, 8'h01, "R9 dec 00");
        run(7, 8'h01, 8'h00, 8'h20, "R9 dec 01");
    endtask

    task automatic t_shift();
        run(12, 8'h81, 8'h00, 8'h20, "R10 lsl");
        run(12, 8'h80, 8'h00, 8'h00, "R10 lsl zero");
        run(13, 8'h01, 8'h00, 8'h00, "R10 lsr");
        run(16, 8'h81, 8'h00, 8'h00, "R10 asr keep msb");
        run(16, 8'h40, 8'h00, 8'h01, "R10 asr");
        run(14, 8'h80, 8'h00, 8'h01, "R11 rol c in");
        run(14, 8'h40, 8'h00, 8'h00, "R11 rol");
        run(15, 8'h01, 8'h00, 8'h01, "R11 ror c in");
        run(15, 8'h02, 8'h00, 8'h00, "R11 ror");
    endtask

    task automatic t_swap();
        run(17, 8'hA5, 8'h00, 8'h5A, "R12 swap");
        run(17, 8'h0F, 8'h00, 8'hFF, "R12 swap flags");
        run(20, 8'h3C, 8'h11, 8'hC3, "R12 unused code");
        run(31, 8'h00, 8'hFF, 8'h7E, "R12 unused top");
    endtask

    task automatic t_sweep();
        int seed;
        seed = 32'h1234;
        for (int i = 0; i < 600; i++) begin
            int op, a, b, s;
            seed = (seed * 1103515245 + 12345) & 32'h7FFFFFFF;
            op = (seed >> 8) % 18;
            a  = (seed >> 3) & 255;
            b  = (seed >> 13) & 255;
            s  = (seed >> 21) & 255;
            run(op, a, b, s[7:0], "R2 R13 sweep");
        end
    endtask

    initial begin
        t_reset();
        t_add();
        t_sub();
        t_sticky();
        t_logic();
        t_incdec();
        t_shift();
        t_swap();
        t_sweep();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule